// File: doc/BRIEF.md
# Byte-Loaded Multi-Mode Logic Cell

This block is a small programmable logic cell. A byte stream delivers one configuration record at a time. The first byte of a record picks the cell structure. The bytes that follow give one selector per LUT pin and the truth tables. Once a record has been fully loaded, the cell computes a Boolean function of up to nine leaf inputs on a single combinational output.

Three structures are available:
- a lone 4-input LUT;
- a chain of two 4-input LUTs, where the first LUT drives the top pin of the second;
- two independent 4-input LUTs whose outputs meet in a 2:1 multiplexer with a selectable steering input.

Each pin selector can tie its pin to constant 0, tie it to constant 1, or route any leaf to it.

Incoming bytes are collected in a staging area. The live configuration changes only when the last byte of a record is taken, so the output never shows a partly loaded function. A malformed header or an out-of-range selector is reported on an error line.

Top module: `lcell_top`

## Requirements
- R1: The header byte (record byte 0) selects the structure: 0 is a single LUT, 1 is a cascade and 2 is a multiplexed pair. The record then totals 7, 12 or 14 bytes. `rec_done` is high for exactly one cycle, in the cycle after the final byte is accepted, and the new function is visible on `func_out` from that same cycle.
- R2: Until the final byte of a record is accepted, `func_out` keeps computing the previously committed function.
- R3: A selector byte value of 0 drives constant 0 onto its pin, 1 drives constant 1, and a value k in the range 2..NLEAF+1 drives `leaf_in[k-2]`.
- R4: In every LUT, pin 0 is the least significant bit of the truth-table index, so the LUT output is `tt[{p3,p2,p1,p0}]`. Each 16-bit truth table arrives as two bytes, high byte first.
- R5: In a type 0 record, bytes 1..4 are the selectors for pins 0..3, bytes 5 and 6 form the truth table, and the output is that LUT.
- R6: In a type 1 record:
  - bytes 1..4 select the pins of the first LUT;
  - bytes 5..7 select pins 0..2 of the second LUT, whose pin 3 is the first LUT's output;
  - bytes 8–9 and 10–11 hold the first and second truth tables;
  - the output is the second LUT.
- R7: In a type 2 record:
  - bytes 1..4 select the pins of LUT A, bytes 5..8 select the pins of LUT B, and byte 9 selects the steering input;
  - bytes 10–11 and 12–13 hold the truth tables of A and B;
  - the output is B when the steering input is 1 and A when it is 0.
- R8: A header byte above 2 raises `rec_err` for one cycle, without `rec_done`, in the cycle after that byte. The byte is dropped, the next byte is taken as a new header, and the live configuration is unchanged.
- R9: A selector above NLEAF+1 raises `rec_err` together with `rec_done` when the record commits, and the affected pin reads constant 0.
- R10: Byte slots with `cfg_valid` low are ignored, whatever the value on `cfg_byte`. `cfg_ready` is always high.
- R11: After reset the live function is constant 0, and `rec_done` and `rec_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_byte | input | 8 | Configuration stream byte |
| cfg_valid | input | 1 | `cfg_byte` carries a byte this cycle |
| cfg_ready | output | 1 | Cell can take a byte (always high) |
| rec_done | output | 1 | One-cycle pulse: a record was committed |
| rec_err | output | 1 | One-cycle pulse: bad header or out-of-range selector |
| leaf_in | input | NLEAF | Leaf input vector |
| func_out | output | 1 | Combinational function output |

## Verification
The bench builds the cell with the default of nine leaves, so the largest legal selector is 10 and the first illegal one is 11. Both values sit on a directed boundary check, next to 0xFF. With nine leaves, a type 2 record uses every selector slot, so random records in all three modes cover every pin route and the full steering path. Random idle slots between bytes carry garbage data, which exercises the valid qualification while the record layouts are being checked.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

    localparam int NSEL     = 9;   // selector slots in the widest structure
    localparam int BODY_MAX = 13;  // bytes after the header in the longest record
    localparam int IDX_W    = $clog2(BODY_MAX + 1);

    typedef enum logic [1:0] {
        K_SINGLE  = 2'd0,
        K_CASCADE = 2'd1,
        K_MUXED   = 2'd2,
        K_BAD     = 2'd3
    } kind_e;

    typedef logic [BODY_MAX-1:0][7:0] body_t;

    typedef struct packed {
        kind_e                 kind;
        logic [NSEL-1:0][7:0]  sel;
        logic [15:0]           tt_a;
        logic [15:0]           tt_b;
    } cell_cfg_t;

    // number of bytes that follow the header
    function automatic logic [IDX_W-1:0] body_len(kind_e k);
        case (k)
            K_SINGLE:  return IDX_W'(6);
            K_CASCADE: return IDX_W'(11);
            default:   return IDX_W'(13);
        endcase
    endfunction

    // b[i] holds record byte i+1
    function automatic cell_cfg_t unpack_body(kind_e k, body_t b);
        cell_cfg_t c;
        c      = '0;
        c.kind = k;
        for (int i = 0; i < 4; i++) c.sel[i] = b[i];
        case (k)
            K_SINGLE: begin
                c.tt_a = {b[4], b[5]};
            end
            K_CASCADE: begin
                for (int i = 4; i < 7; i++) c.sel[i] = b[i];
                c.tt_a = {b[7], b[8]};
                c.tt_b = {b[9], b[10]};
            end
            default: begin
                for (int i = 4; i < NSEL; i++) c.sel[i] = b[i];
                c.tt_a = {b[9], b[10]};
                c.tt_b = {b[11], b[12]};
            end
        endcase
        return c;
    endfunction

    function automatic logic any_sel_above(cell_cfg_t c, int unsigned lim);
        logic bad;
        bad = 1'b0;
        for (int i = 0; i < NSEL; i++)
            if (int'(c.sel[i]) > int'(lim)) bad = 1'b1;
        return bad;
    endfunction

endpackage

// File: rtl/lcell_lut4.sv
module lcell_lut4 (
    input  logic [15:0] tt_i,
    input  logic [3:0]  idx_i,
    output logic        y_o
);
    assign y_o = tt_i[idx_i];
endmodule

// File: rtl/lcell_pinsel.sv
module lcell_pinsel
    import lcell_pkg::*;
#(
    parameter int NLEAF = 9
) (
    input  logic [NSEL-1:0][7:0] sel_i,
    input  logic [NLEAF-1:0]     leaf_i,
    output logic [NSEL-1:0]      pin_o
);
    function automatic logic route(logic [7:0] s, logic [NLEAF-1:0] lv);
        logic r;
        r = 1'b0;
        if (s == 8'd1) r = 1'b1;
        for (int l = 0; l < NLEAF; l++)
            if (int'(s) == l + 2) r = lv[l];
        return r;
    endfunction

    for (genvar g = 0; g < NSEL; g++) begin : g_pin
        assign pin_o[g] = route(sel_i[g], leaf_i);
    end
endmodule

// File: rtl/lcell_loader.sv
module lcell_loader
    import lcell_pkg::*;
#(
    parameter int NLEAF = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] byte_i,
    input  logic       valid_i,
    output cell_cfg_t  cfg_o,
    output logic       done_o,
    output logic       err_o,
    output logic       hdr_wait_o
);
    localparam int unsigned SEL_MAX = NLEAF + 1;

    typedef struct packed {
        logic            busy;
        kind_e           kind;
        logic [IDX_W-1:0] idx;
        body_t           body;
        cell_cfg_t       cfg;
        logic            done;
        logic            err;
    } ld_state_t;

    ld_state_t st_d, st_q;
    body_t     body_nxt;
    cell_cfg_t cand;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        body_nxt  = st_q.body;
        for (int i = 0; i < BODY_MAX; i++)
            if (int'(st_q.idx) == i) body_nxt[i] = byte_i;
        cand = unpack_body(st_q.kind, body_nxt);
        if (valid_i) begin
            if (!st_q.busy) begin
                if (byte_i <= 8'd2) begin
                    st_d.busy = 1'b1;
                    st_d.kind = kind_e'(byte_i[1:0]);
                    st_d.idx  = '0;
                    st_d.body = '0;
                end else begin
                    st_d.err  = 1'b1;
                end
            end else begin
                st_d.body = body_nxt;
                if (st_q.idx == body_len(st_q.kind) - IDX_W'(1)) begin
                    st_d.busy = 1'b0;
                    st_d.cfg  = cand;
                    st_d.done = 1'b1;
                    st_d.err  = any_sel_above(cand, SEL_MAX);
                end else begin
                    st_d.idx  = st_q.idx + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o      = st_q.cfg;
    assign done_o     = st_q.done;
    assign err_o      = st_q.err;
    assign hdr_wait_o = !st_q.busy;
endmodule

// File: rtl/lcell_top.sv
module lcell_top
    import lcell_pkg::*;
#(
    parameter int NLEAF = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       cfg_byte,
    input  logic             cfg_valid,
    output logic             cfg_ready,
    output logic             rec_done,
    output logic             rec_err,
    input  logic [NLEAF-1:0] leaf_in,
    output logic             func_out
);
    cell_cfg_t       act_cfg;
    kind_e           act_kind;
    logic            hdr_wait;
    logic [NSEL-1:0] pin;
    logic [3:0]      idx_b;
    logic            y_a;
    logic            y_b;

    assign cfg_ready = 1'b1;
    assign act_kind  = act_cfg.kind;

    lcell_loader #(.NLEAF(NLEAF)) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_i     (cfg_byte),
        .valid_i    (cfg_valid),
        .cfg_o      (act_cfg),
        .done_o     (rec_done),
        .err_o      (rec_err),
        .hdr_wait_o (hdr_wait)
    );

    lcell_pinsel #(.NLEAF(NLEAF)) u_pinsel (
        .sel_i  (act_cfg.sel),
        .leaf_i (leaf_in),
        .pin_o  (pin)
    );

    lcell_lut4 u_lut_a (
        .tt_i  (act_cfg.tt_a),
        .idx_i (pin[3:0]),
        .y_o   (y_a)
    );

    assign idx_b = (act_kind == K_CASCADE) ? {y_a, pin[6:4]} : pin[7:4];

    lcell_lut4 u_lut_b (
        .tt_i  (act_cfg.tt_b),
        .idx_i (idx_b),
        .y_o   (y_b)
    );

    always_comb begin
        case (act_kind)
            K_SINGLE:  func_out = y_a;
            K_CASCADE: func_out = y_b;
            K_MUXED:   func_out = pin[8] ? y_b : y_a;
            default:   func_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/lcell_top_chk.sv
module lcell_top_chk
    import lcell_pkg::*;
#(
    parameter int NLEAF = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       cfg_byte,
    input logic             cfg_valid,
    input logic             rec_done,
    input logic             rec_err,
    input logic [NLEAF-1:0] leaf_in,
    input logic             func_out,
    input logic             hdr_wait,
    input kind_e            act_kind
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |=> !rec_done); // R1
    AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |-> $past(cfg_valid)); // R1
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        act_kind != K_BAD); // R1
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec_done && $stable(leaf_in)) |-> $stable(func_out)); // R2
    AST_BAD_HDR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_wait && cfg_valid && cfg_byte > 8'd2) |=> (rec_err && !rec_done)); // R8
    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_err |-> (rec_done || $past(hdr_wait && cfg_valid && cfg_byte > 8'd2))); // R9
endmodule

bind lcell_top lcell_top_chk #(.NLEAF(NLEAF)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_byte  (cfg_byte),
    .cfg_valid (cfg_valid),
    .rec_done  (rec_done),
    .rec_err   (rec_err),
    .leaf_in   (leaf_in),
    .func_out  (func_out),
    .hdr_wait  (hdr_wait),
    .act_kind  (act_kind)
);

// File: tb/lcell_top_bench.sv
module lcell_top_bench;
    localparam int NLEAF = 9;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n;
    logic [7:0]       cfg_byte;
    logic             cfg_valid;
    logic             cfg_ready;
    logic             rec_done;
    logic             rec_err;
    logic [NLEAF-1:0] leaf_in;
    logic             func_out;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    logic [7:0] m_rec [14];

    lcell_top #(.NLEAF(NLEAF)) u_lcell_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_byte  (cfg_byte),
        .cfg_valid (cfg_valid),
        .cfg_ready (cfg_ready),
        .rec_done  (rec_done),
        .rec_err   (rec_err),
        .leaf_in   (leaf_in),
        .func_out  (func_out)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog R1 actual=%0d expected=<50000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic pv(logic [7:0] s, logic [NLEAF-1:0] lv);
        if (s == 8'd1) return 1'b1;
        if (int'(s) >= 2 && int'(s) <= NLEAF + 1) return lv[int'(s) - 2];
        return 1'b0;
    endfunction

    function automatic logic model_out(logic [NLEAF-1:0] lv);
        logic [3:0]  ia, ib;
        logic [15:0] ta, tb;
        ia = {pv(m_rec[4], lv), pv(m_rec[3], lv), pv(m_rec[2], lv), pv(m_rec[1], lv)};
        case (m_rec[0])
            8'd0: begin
                ta = {m_rec[5], m_rec[6]};
                return ta[ia];
            end
            8'd1: begin
                ta = {m_rec[8], m_rec[9]};
                tb = {m_rec[10], m_rec[11]};
                ib = {ta[ia], pv(m_rec[7], lv), pv(m_rec[6], lv), pv(m_rec[5], lv)};
                return tb[ib];
            end
            default: begin
                ta = {m_rec[10], m_rec[11]};
                tb = {m_rec[12], m_rec[13]};
                ib = {pv(m_rec[8], lv), pv(m_rec[7], lv), pv(m_rec[6], lv), pv(m_rec[5], lv)};
                return pv(m_rec[9], lv) ? tb[ib] : ta[ia];
            end
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after acceptance (R10 gaps)
    task automatic put_byte(logic [7:0] b);
        int gap;
        gap = $urandom_range(0, 2);
        for (int i = 0; i < gap; i++) begin
            cfg_valid = 1'b0;
            cfg_byte  = 8'($urandom);
            @(negedge clk);
        end
        cfg_byte  = b;
        cfg_valid = 1'b1;
        @(negedge clk);
        cfg_valid = 1'b0;
        cfg_byte  = 8'($urandom);
    endtask

    task automatic probe(string tag, int n);
        for (int i = 0; i < n; i++) begin
            leaf_in = NLEAF'($urandom);
            #1;
            check(tag, int'(func_out), int'(model_out(leaf_in)));
        end
        @(negedge clk);
    endtask

    task automatic send_rec(logic [7:0] r [14], int len, int exp_err, string tag);
        for (int i = 0; i < len - 1; i++) put_byte(r[i]);
        leaf_in = NLEAF'($urandom);
        #1;
        check({tag, " R2 old function held"}, int'(func_out), int'(model_out(leaf_in)));
        check({tag, " R1 no early done"}, int'(rec_done), 0);
        @(negedge clk);
        put_byte(r[len - 1]);
        check({tag, " R1 done pulse"}, int'(rec_done), 1);
        check({tag, " R9 error flag"}, int'(rec_err), exp_err);
        m_rec = r;
        probe({tag, " R1 new function"}, 2);
        check({tag, " R1 done single cycle"}, int'(rec_done), 0);
        probe(tag, 2);
    endtask

    task automatic rand_rec(output logic [7:0] r [14], output int len);
        int t, nsel;
        t    = $urandom_range(0, 2);
        len  = (t == 0) ? 7 : ((t == 1) ? 12 : 14);
        nsel = (t == 0) ? 4 : ((t == 1) ? 7 : 9);
        for (int i = 0; i < 14; i++) r[i] = 8'($urandom);
        r[0] = 8'(t);
        for (int i = 1; i <= nsel; i++) r[i] = 8'($urandom_range(0, 10));
    endtask

    initial begin
        logic [7:0] r [14];
        int len;
        void'($urandom(32'd7741));
        rst_n = 1'b0; cfg_valid = 1'b0; cfg_byte = '0; leaf_in = '0;
        for (int i = 0; i < 14; i++) m_rec[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset output", int'(func_out), 0);
        check("R11 reset done", int'(rec_done), 0);
        check("R11 reset err", int'(rec_err), 0);
        check("R10 ready", int'(cfg_ready), 1);
        probe("R11 reset function", 3);

        // R4 byte order: high byte 0x00, low 0x01 -> only index 0 set
        r = '{0, 0,0,0,0, 8'h00,8'h01, 0,0,0,0,0,0,0};
        send_rec(r, 7, 0, "R4 R5 byte order");
        leaf_in = NLEAF'($urandom); #1;
        check("R4 byte order literal", int'(func_out), 1);
        @(negedge clk);

        // R4 pin order: pin0 = leaf0, tt = 0x0002
        r = '{0, 2,0,0,0, 8'h00,8'h02, 0,0,0,0,0,0,0};
        send_rec(r, 7, 0, "R4 pin0");
        for (int i = 0; i < 3; i++) begin
            leaf_in = NLEAF'($urandom); #1;
            check("R4 pin0 is LSB", int'(func_out), int'(leaf_in[0]));
        end
        @(negedge clk);

        // pin3 = leaf0, tt = 0x0100 -> index 8
        r = '{0, 0,0,0,2, 8'h01,8'h00, 0,0,0,0,0,0,0};
        send_rec(r, 7, 0, "R4 pin3");
        for (int i = 0; i < 3; i++) begin
            leaf_in = NLEAF'($urandom); #1;
            check("R4 pin3 is MSB", int'(func_out), int'(leaf_in[0]));
        end
        @(negedge clk);

        // R3 constants: all pins tied to 1 -> index 15
        r = '{0, 1,1,1,1, 8'h80,8'h00, 0,0,0,0,0,0,0};
        send_rec(r, 7, 0, "R3 const one");
        leaf_in = NLEAF'($urandom); #1;
        check("R3 const one literal", int'(func_out), 1);
        @(negedge clk);

        // R9 boundary: selector 10 is the last leaf, 11 is illegal
        r = '{0, 10,0,0,0, 8'h00,8'h02, 0,0,0,0,0,0,0};
        send_rec(r, 7, 0, "R3 last leaf");
        for (int i = 0; i < 3; i++) begin
            leaf_in = NLEAF'($urandom); #1;
            check("R3 selector 10 routes leaf 8", int'(func_out), int'(leaf_in[8]));
        end
        @(negedge clk);
        r = '{0, 11,0,0,0, 8'h00,8'h02, 0,0,0,0,0,0,0};
        send_rec(r, 7, 1, "R9 selector 11");
        leaf_in = '1; #1;
        check("R9 illegal pin reads 0", int'(func_out), 0);
        @(negedge clk);
        r = '{0, 8'hFF,0,0,0, 8'h00,8'h02, 0,0,0,0,0,0,0};
        send_rec(r, 7, 1, "R9 selector 255");
        leaf_in = '1; #1;
        check("R9 selector 255 reads 0", int'(func_out), 0);
        @(negedge clk);

        // R6 cascade: (l0 & l1) ^ l2
        r = '{1, 2,3,1,1, 4,0,0, 8'h80,8'h00, 8'h01,8'h02, 0,0};
        send_rec(r, 12, 0, "R6 cascade");
        for (int i = 0; i < 4; i++) begin
            leaf_in = NLEAF'($urandom); #1;
            check("R6 cascade literal", int'(func_out),
                  int'((leaf_in[0] & leaf_in[1]) ^ leaf_in[2]));
        end
        @(negedge clk);

        // R7 mux: l2 ? l1 : l0
        r = '{2, 2,0,0,0, 3,0,0,0, 4, 8'hAA,8'hAA, 8'hAA,8'hAA};
        send_rec(r, 14, 0, "R7 mux");
        for (int i = 0; i < 4; i++) begin
            leaf_in = NLEAF'($urandom); #1;
            check("R7 mux literal", int'(func_out),
                  int'(leaf_in[2] ? leaf_in[1] : leaf_in[0]));
        end
        @(negedge clk);

        // R8 bad headers
        put_byte(8'd3);
        check("R8 bad header err", int'(rec_err), 1);
        check("R8 bad header no done", int'(rec_done), 0);
        probe("R8 config kept", 2);
        put_byte(8'hFF);
        check("R8 bad header 0xFF err", int'(rec_err), 1);
        probe("R8 config kept 0xFF", 2);
        rand_rec(r, len);
        send_rec(r, len, 0, "R8 recovery");

        // random records in all modes
        for (int n = 0; n < 80; n++) begin
            rand_rec(r, len);
            send_rec(r, len, 0, "R5 R6 R7 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule